// File: doc/BRIEF.md
# Link Error Counter Monitor

This block watches the error indications produced by a serial link decoder. It keeps two saturating counters. One counts errors that the decoder detected but could not repair. The other counts errors that the decoder corrected. Each counter is compared with its own programmable threshold. When either count passes its threshold, or when a pseudo-random (PRBS) link test reports a mismatch, the block asserts a single sticky, active-low error flag.

The counters and the flag are cleared in three ways:
- when the link regains lock;
- when software reads a counter, signalled by a per-counter read strobe;
- by an optional automatic reset, which fires after the flag has been held low for a fixed time of about one microsecond.

The automatic reset is blocked while the link is in PRBS test mode. While the link is out of lock, no errors are accumulated.

Top module: `lerr_monitor`

## Requirements
- R1: After reset both counters read 0 and `errFlagN` is 1.
- R2: A `detErrStb` (or `corrErrStb`) pulse sampled while `linkLocked`=1 and `prbsMode`=0 raises `detCount` (or `corrCount`) by one at the next clock edge. The two counters are independent.
- R3: A counter holds at 255 instead of wrapping when further error strobes arrive.
- R4: While `linkLocked`=0, error strobes do not change either counter.
- R5: On the first cycle in which `linkLocked` is 1 after being 0, both counters become 0 at the next edge and any error strobe in that cycle is dropped. The flag is released at that edge.
- R6: `rdDetStb` clears only `detCount`, and `rdCorrStb` clears only `corrCount`, at the next edge. If a counted error strobe for the same counter arrives in the same cycle, that counter loads 1.
- R7: With `prbsMode`=0, `errFlagN` goes to 0 one edge after a cycle in which `detCount` > `detThresh` or `corrCount` > `corrThresh`. It then stays 0 until a clear event.
- R8: Any clear event releases the flag (`errFlagN`=1) at the next edge. The clear events are a lock rise, either read strobe, or the automatic reset. If a threshold is still exceeded after the clear, the flag asserts again one edge later.
- R9: While `prbsMode`=1, both counters are 0 from the next edge and error strobes are ignored. A `prbsErrStb` pulse sets the flag at the next edge.
- R10: With `autoRstEn`=1 and `prbsMode`=0, once `errFlagN` has been 0 for AUTO_DLY consecutive cycles, both counters clear and `errFlagN` returns to 1. AUTO_DLY is `CLK_HZ`/10^6 × `AUTO_RST_NS`/1000, which is 50 at the defaults. The delay restarts only when the flag asserts again.
- R11: With `autoRstEn`=0, or while `prbsMode`=1, the flag is never released by time alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| detErrStb | input | 1 | One detected (uncorrected) symbol error this cycle |
| corrErrStb | input | 1 | One corrected symbol error this cycle |
| linkLocked | input | 1 | Link lock status, level |
| prbsMode | input | 1 | PRBS test mode active |
| prbsErrStb | input | 1 | PRBS checker mismatch this cycle |
| rdDetStb | input | 1 | Read of the detected-error counter |
| rdCorrStb | input | 1 | Read of the corrected-error counter |
| autoRstEn | input | 1 | Enable for the timed automatic reset |
| detThresh | input | CNT_W | Threshold for the detected-error count |
| corrThresh | input | CNT_W | Threshold for the corrected-error count |
| detCount | output | CNT_W | Detected-error count |
| corrCount | output | CNT_W | Corrected-error count |
| errFlagN | output | 1 | Error flag, active low |

## Verification
The bench targets the following corner cases, and each one catches a specific kind of mistake:

- **Read and error in the same cycle.** A design that let the clear win would show 0 instead of 1 after such a cycle.
- **Strobes while out of lock.** A counter that kept accumulating while lock was lost would show up here.
- **Error on the lock-rise cycle.** An error strobe arriving exactly on the cycle lock returns must be dropped.
- **Saturation.** A counter that wrapped would read 44 instead of 255 after 300 strobes.
- **Flag reassertion after reading the wrong counter.** A flag that stayed released after only the other counter was read would be caught.
- **Automatic-reset timing.** The bench measures the exact low time of the flag. An off-by-one timer changes that width.
- **Automatic reset while disabled or in PRBS mode.** A reset that fired in either case would release the flag early.

// File: rtl/lerr_pkg.sv
package lerr_pkg;
  // Per-cycle commands from control to the counter datapath
  typedef struct packed {
    logic clrDet;
    logic clrCorr;
    logic incDet;
    logic incCorr;
  } cntCtl_t;
endpackage

// File: rtl/lerr_sat_counter.sv
module lerr_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_ONE = W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       count <= '0;
    else if (clr)                    count <= inc ? CNT_ONE : '0;
    else if (inc && count != CNT_MAX) count <= count + CNT_ONE;
  end

  assert_sat_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_MAX && inc && !clr) |=> count == CNT_MAX);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && inc && count != CNT_MAX) |=> count == $past(count) + CNT_ONE);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (count == '0 || count == CNT_ONE));
endmodule

// File: rtl/lerr_datapath.sv
module lerr_datapath
  import lerr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  cntCtl_t      ctl,
  input  logic [W-1:0] detThresh,
  input  logic [W-1:0] corrThresh,
  output logic [W-1:0] detCount,
  output logic [W-1:0] corrCount,
  output logic         overDet,
  output logic         overCorr
);
  localparam int NCH = 2;

  logic         clrV [NCH];
  logic         incV [NCH];
  logic [W-1:0] thrV [NCH];
  logic [W-1:0] cntV [NCH];
  logic         overV[NCH];

  assign clrV[0] = ctl.clrDet;
  assign incV[0] = ctl.incDet;
  assign thrV[0] = detThresh;
  assign clrV[1] = ctl.clrCorr;
  assign incV[1] = ctl.incCorr;
  assign thrV[1] = corrThresh;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    lerr_sat_counter #(.W(W)) i_cnt (
      .clk  (clk),
      .rstN (rstN),
      .clr  (clrV[ch]),
      .inc  (incV[ch]),
      .count(cntV[ch])
    );
    assign overV[ch] = cntV[ch] > thrV[ch];
  end

  assign detCount  = cntV[0];
  assign corrCount = cntV[1];
  assign overDet   = overV[0];
  assign overCorr  = overV[1];
endmodule

// File: rtl/lerr_ctrl.sv
module lerr_ctrl
  import lerr_pkg::*;
#(
  parameter int AUTO_DLY = 50
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    detErrStb,
  input  logic    corrErrStb,
  input  logic    linkLocked,
  input  logic    prbsMode,
  input  logic    prbsErrStb,
  input  logic    rdDetStb,
  input  logic    rdCorrStb,
  input  logic    autoRstEn,
  input  logic    overDet,
  input  logic    overCorr,
  output cntCtl_t ctl,
  output logic    errFlag
);
  localparam int AGE_W = (AUTO_DLY > 1) ? $clog2(AUTO_DLY) : 1;
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(AUTO_DLY - 1);

  logic             lockQ;
  logic             lockRise;
  logic             autoRst;
  logic             wipeAll;
  logic             countOk;
  logic             flagSet;
  logic             flagClr;
  logic [AGE_W-1:0] ageCnt;

  assign lockRise = linkLocked & ~lockQ;
  assign autoRst  = errFlag & autoRstEn & ~prbsMode & (ageCnt == AGE_LAST);
  assign wipeAll  = lockRise | autoRst | prbsMode;
  assign countOk  = linkLocked & ~wipeAll;

  always_comb begin
    ctl.clrDet  = wipeAll | rdDetStb;
    ctl.clrCorr = wipeAll | rdCorrStb;
    ctl.incDet  = detErrStb & countOk;
    ctl.incCorr = corrErrStb & countOk;
  end

  assign flagSet = prbsMode ? prbsErrStb : (overDet | overCorr);
  assign flagClr = lockRise | autoRst | rdDetStb | rdCorrStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ   <= 1'b0;
      errFlag <= 1'b0;
      ageCnt  <= '0;
    end else begin
      lockQ   <= linkLocked;
      errFlag <= flagClr ? 1'b0 : (errFlag | flagSet);
      if (!errFlag)               ageCnt <= '0;
      else if (ageCnt != AGE_LAST) ageCnt <= ageCnt + AGE_W'(1);
    end
  end

  assert_prbs_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (prbsMode && prbsErrStb && !rdDetStb && !rdCorrStb && linkLocked && lockQ) |=> errFlag);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdDetStb || rdCorrStb) |=> !errFlag);

  assert_lock_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    (linkLocked && !lockQ) |=> !errFlag);

  assert_age_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> ageCnt == '0);

  assert_no_auto_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && (!autoRstEn || prbsMode) && !rdDetStb && !rdCorrStb && !(linkLocked && !lockQ))
      |=> errFlag);
endmodule

// File: rtl/lerr_monitor.sv
module lerr_monitor
  import lerr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int CLK_HZ      = 50_000_000,
  parameter int AUTO_RST_NS = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             detErrStb,
  input  logic             corrErrStb,
  input  logic             linkLocked,
  input  logic             prbsMode,
  input  logic             prbsErrStb,
  input  logic             rdDetStb,
  input  logic             rdCorrStb,
  input  logic             autoRstEn,
  input  logic [CNT_W-1:0] detThresh,
  input  logic [CNT_W-1:0] corrThresh,
  output logic [CNT_W-1:0] detCount,
  output logic [CNT_W-1:0] corrCount,
  output logic             errFlagN
);
  localparam int DLY_RAW  = (CLK_HZ / 1_000_000) * AUTO_RST_NS / 1000;
  localparam int AUTO_DLY = (DLY_RAW < 1) ? 1 : DLY_RAW;

  cntCtl_t ctl;
  logic    overDet;
  logic    overCorr;
  logic    errFlag;

  lerr_ctrl #(.AUTO_DLY(AUTO_DLY)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .detErrStb (detErrStb),
    .corrErrStb(corrErrStb),
    .linkLocked(linkLocked),
    .prbsMode  (prbsMode),
    .prbsErrStb(prbsErrStb),
    .rdDetStb  (rdDetStb),
    .rdCorrStb (rdCorrStb),
    .autoRstEn (autoRstEn),
    .overDet   (overDet),
    .overCorr  (overCorr),
    .ctl       (ctl),
    .errFlag   (errFlag)
  );

  lerr_datapath #(.W(CNT_W)) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .detThresh (detThresh),
    .corrThresh(corrThresh),
    .detCount  (detCount),
    .corrCount (corrCount),
    .overDet   (overDet),
    .overCorr  (overCorr)
  );

  assign errFlagN = ~errFlag;

  assert_prbs_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    prbsMode |=> (detCount == '0 && corrCount == '0));

  assert_unlocked_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !linkLocked |=> (detCount == '0 || detCount == $past(detCount)));
endmodule

// File: tb/test_lerr_monitor.sv
module test_lerr_monitor;
  localparam int DLY = 50;  // 1 us at 50 MHz

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic detErrStb = 0, corrErrStb = 0, linkLocked = 0, prbsMode = 0;
  logic prbsErrStb = 0, rdDetStb = 0, rdCorrStb = 0, autoRstEn = 0;
  logic [7:0] detThresh = 8'd5, corrThresh = 8'd200;
  logic [7:0] detCount, corrCount;
  logic errFlagN;

  int nChecks = 0, nFail = 0;
  string curReq = "R1";
  bit finished = 0;

  // reference model state
  int mDet = 0, mCorr = 0, mFlag = 0, mAge = 0, mLockQ = 0;

  always #10 clk = ~clk;

  lerr_monitor i_lerr_monitor (
    .clk(clk), .rstN(rstN), .detErrStb(detErrStb), .corrErrStb(corrErrStb),
    .linkLocked(linkLocked), .prbsMode(prbsMode), .prbsErrStb(prbsErrStb),
    .rdDetStb(rdDetStb), .rdCorrStb(rdCorrStb), .autoRstEn(autoRstEn),
    .detThresh(detThresh), .corrThresh(corrThresh),
    .detCount(detCount), .corrCount(corrCount), .errFlagN(errFlagN)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mDet = 0; mCorr = 0; mFlag = 0; mAge = 0; mLockQ = 0;
    end else begin
      bit lr, ar, wipe, ok, setC, clrC;
      int nDet, nCorr;
      lr   = linkLocked && !mLockQ;
      ar   = mFlag != 0 && autoRstEn && !prbsMode && mAge >= DLY - 1;
      wipe = lr || ar || prbsMode;
      ok   = linkLocked && !wipe;
      if (wipe) nDet = 0;
      else if (rdDetStb) nDet = (detErrStb && ok) ? 1 : 0;
      else if (detErrStb && ok && mDet < 255) nDet = mDet + 1;
      else nDet = mDet;
      if (wipe) nCorr = 0;
      else if (rdCorrStb) nCorr = (corrErrStb && ok) ? 1 : 0;
      else if (corrErrStb && ok && mCorr < 255) nCorr = mCorr + 1;
      else nCorr = mCorr;
      setC = prbsMode ? prbsErrStb : (mDet > detThresh || mCorr > corrThresh);
      clrC = lr || ar || rdDetStb || rdCorrStb;
      mAge = (mFlag != 0) ? mAge + 1 : 0;
      mFlag = clrC ? 0 : ((mFlag != 0 || setC) ? 1 : 0);
      mDet = nDet; mCorr = nCorr; mLockQ = linkLocked;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
    check({curReq, " model det"},  detCount,  mDet);
    check({curReq, " model corr"}, corrCount, mCorr);
    check({curReq, " model flag"}, errFlagN,  mFlag ? 0 : 1);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) tick();
    rstN = 1;
    tick();
    check("R1 det", detCount, 0); check("R1 corr", corrCount, 0); check("R1 flag", errFlagN, 1);

    curReq = "R2"; linkLocked = 1; tick(); tick();
    detErrStb = 1; repeat (3) tick(); detErrStb = 0;
    corrErrStb = 1; repeat (2) tick(); corrErrStb = 0;
    check("R2 det", detCount, 3); check("R2 corr", corrCount, 2);

    curReq = "R7"; detErrStb = 1; repeat (3) tick(); detErrStb = 0;
    check("R7 flag not yet", errFlagN, 1);
    tick(); check("R7 flag set", errFlagN, 0);
    repeat (3) tick(); check("R7 sticky", errFlagN, 0);

    curReq = "R6"; rdDetStb = 1; tick(); rdDetStb = 0;
    check("R6 det cleared", detCount, 0); check("R6 corr kept", corrCount, 2);
    check("R8 release on read", errFlagN, 1);
    rdCorrStb = 1; corrErrStb = 1; tick(); rdCorrStb = 0; corrErrStb = 0;
    check("R6 load one", corrCount, 1);

    curReq = "R8"; corrThresh = 0; tick(); check("R8 set", errFlagN, 0);
    rdDetStb = 1; tick(); rdDetStb = 0; check("R8 released", errFlagN, 1);
    tick(); check("R8 reassert", errFlagN, 0);
    rdCorrStb = 1; tick(); rdCorrStb = 0; corrThresh = 255; tick();

    curReq = "R3"; corrErrStb = 1; repeat (300) tick(); corrErrStb = 0;
    check("R3 saturate", corrCount, 255);

    curReq = "R4"; linkLocked = 0; tick();
    detErrStb = 1; corrErrStb = 1; repeat (5) tick(); detErrStb = 0; corrErrStb = 0;
    check("R4 det held", detCount, 0); check("R4 corr held", corrCount, 255);

    curReq = "R5"; detErrStb = 1; linkLocked = 1; tick(); detErrStb = 0;
    check("R5 det", detCount, 0); check("R5 corr", corrCount, 0);

    curReq = "R10"; autoRstEn = 1; detThresh = 0;
    detErrStb = 1; tick(); detErrStb = 0;
    n = 0; tick();
    while (errFlagN == 0 && n < 1000) begin n++; tick(); end
    check("R10 low width", n, DLY); check("R10 det cleared", detCount, 0);

    curReq = "R11"; autoRstEn = 0;
    detErrStb = 1; tick(); detErrStb = 0;
    repeat (3 * DLY) tick(); check("R11 no auto when off", errFlagN, 0);
    rdDetStb = 1; tick(); rdDetStb = 0; detThresh = 200; tick();

    curReq = "R9"; autoRstEn = 1;
    detErrStb = 1; repeat (4) tick(); detErrStb = 0;
    prbsMode = 1; detErrStb = 1; tick(); tick(); detErrStb = 0;
    check("R9 det zero", detCount, 0); check("R9 flag idle", errFlagN, 1);
    prbsErrStb = 1; tick(); prbsErrStb = 0; check("R9 prbs flag", errFlagN, 0);
    curReq = "R11"; repeat (2 * DLY) tick(); check("R11 no auto in prbs", errFlagN, 0);
    curReq = "R8"; rdCorrStb = 1; tick(); rdCorrStb = 0; check("R8 prbs release", errFlagN, 1);
    prbsMode = 0; repeat (4) tick();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule